// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is one stage of a synchronous binary up-counter with a parallel preset. On each rising clock edge the stage clears, takes a preset value or counts up, depending on three controls. Reset is active low. A parameter selects whether reset clears the stage at once or waits for the next clock edge. The preset strobe is also active low. Two active-high enables, a primary one and a chain one, must both be high before the stage counts.

The chain enable also gates a terminal-count carry. The carry is high only while the stage is at its all-ones value and the chain enable is high. To build a wider counter, feed each stage's carry into the chain enable of the next stage and give all stages the same clock, primary enable and preset strobe. The whole chain then counts as one binary word in a single clock, and no logic is needed between the stages.

Top module: `cascade_count_stage`

## Requirements
- R1: With ASYNC_RESET=1, a low rst_n forces count to 0 as soon as it goes low, without waiting for a clock edge, and count stays 0 while rst_n is low.
- R2: With ASYNC_RESET=0, a low rst_n has no effect between clock edges. It forces count to 0 at the next rising edge.
- R3: When load_n is low at a rising edge and rst_n is high, count takes the value of preset. Counting is suppressed at that edge.
- R4: When rst_n, load_n, en_p and en_t are all high at a rising edge, count goes up by one in plain binary. The all-ones value wraps to 0.
- R5: When load_n and rst_n are high and either en_p or en_t is low at a rising edge, count keeps its value.
- R6: carry equals en_t AND (count is all ones). It has no register, and neither en_p nor load_n affects it.
- R7: When en_t is low, carry is low whatever the values of count, load_n and en_p.
- R8: Priority at an edge is reset first, then load, then count.
- R9: Bit 0 of preset and of count is the least significant bit. Loading preset 0x1 gives count 0x1.
- R10: When stages are chained (the carry of one stage drives en_t of the next, and all other controls are shared), the chain counts as a single binary word. This includes the step across the stage boundary and the wrap from all-ones to zero, and each step takes one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous or synchronous per ASYNC_RESET |
| load_n | input | 1 | Active-low parallel preset strobe |
| en_p | input | 1 | Primary count enable |
| en_t | input | 1 | Chain count enable, also gates carry |
| preset | input | WIDTH | Parallel preset value, bit 0 least significant |
| count | output | WIDTH | Current count |
| carry | output | 1 | Terminal-count carry for the next stage |

## Verification
The bench builds two 8-bit chains from stages at the default WIDTH of 4. One chain uses ASYNC_RESET=1 and the other ASYNC_RESET=0, and both receive the same stimulus. A reset pulse dropped between clock edges therefore shows the two reset variants side by side: the asynchronous chain reads zero before the edge, while the synchronous chain still holds its count. Because the chain is 8 bits wide, every nibble boundary crossing and the wrap from 0xFF to 0x00 take place within a few hundred cycles. The chained carries can then be compared against a single byte model.

// File: rtl/cascade_count_stage.sv
module cascade_count_stage #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             advance;

  assign advance = en_p & en_t;

  always_comb begin
    if (!load_n)      cnt_d = preset;
    else if (advance) cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  generate
    if (ASYNC_RESET) begin : g_async_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end else begin : g_sync_rst
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  assign count = cnt_q;
  assign carry = en_t & (&cnt_q);
endmodule

module cascade_count_stage_chk #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> count == '0); // R2
  AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(preset)); // R3
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_p && en_t) |=> count == WIDTH'($past(count) + 1'b1)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_p && en_t)) |=> $stable(count)); // R5
  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> count == ALL_ONES); // R6
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_t |-> !carry); // R7

  generate
    if (ASYNC_RESET) begin : g_async_chk
      AST_ASYNC_ZERO: assert property (@(posedge clk) !rst_n |-> count == '0); // R1
    end
  endgenerate
endmodule

bind cascade_count_stage cascade_count_stage_chk #(
  .WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
  .preset(preset), .count(count), .carry(carry)
);

// File: tb/cascade_count_stage_bench.sv
`timescale 1ns/1ps
module cascade_count_stage_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, load_n, en_p, en_t;
  logic [7:0] preset;
  logic [3:0] a_lo, a_hi, s_lo, s_hi;
  logic       a_c_lo, a_c_hi, s_c_lo, s_c_hi;
  int tests = 0, fails = 0;
  logic [7:0] model;

  cascade_count_stage #(.WIDTH(4), .ASYNC_RESET(1'b1)) u_cascade_count_stage (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .preset(preset[3:0]), .count(a_lo), .carry(a_c_lo));
  cascade_count_stage #(.WIDTH(4), .ASYNC_RESET(1'b1)) u_cascade_count_stage_ahi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(a_c_lo),
    .preset(preset[7:4]), .count(a_hi), .carry(a_c_hi));
  cascade_count_stage #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_cascade_count_stage_slo (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .preset(preset[3:0]), .count(s_lo), .carry(s_c_lo));
  cascade_count_stage #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_cascade_count_stage_shi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(s_c_lo),
    .preset(preset[7:4]), .count(s_hi), .carry(s_c_hi));

  function automatic logic [7:0] next_val(logic [7:0] m, logic r, logic l, logic p,
                                          logic t, logic [7:0] pre);
    if (!r) return 8'h00;
    if (!l) return pre;
    if (p && t) return m + 8'h01;
    return m;
  endfunction

  function automatic logic want_carry(logic [7:0] m, logic t);
    return t && (m == 8'hFF);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic r, logic l, logic p, logic t, logic [7:0] pre, string tag);
    rst_n = r; load_n = l; en_p = p; en_t = t; preset = pre;
    #0.5;
    chk({tag, " R6 R7 carry async chain"}, {7'd0, a_c_hi}, {7'd0, want_carry(model, t)});
    chk({tag, " R6 R7 carry sync chain"},  {7'd0, s_c_hi}, {7'd0, want_carry(model, t)});
    model = next_val(model, r, l, p, t, pre);
    @(posedge clk); #1;
    chk({tag, " R10 async chain"}, {a_hi, a_lo}, model);
    chk({tag, " R10 sync chain"},  {s_hi, s_lo}, model);
  endtask

  function automatic string tag_of(logic r, logic l, logic p, logic t);
    if (!r) return "R8 reset";
    if (!l) return "R3 load";
    if (p && t) return "R4 count";
    return "R5 hold";
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model = 8'h00;
    rst_n = 1'b0; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; preset = 8'h00;
    @(posedge clk); #1;
    cycle(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R1 R2 reset state");

    cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h01, "R9 lsb load");
    chk("R9 low nibble bit0", {4'd0, a_lo}, 8'h01);

    cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'hFD, "R3 preset");
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R4 R10 wrap");

    cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, "R3 to top");
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R6 en_p low hold");
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h22, "R7 t low with load");
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h22, "R4 step");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h0E, "R3 preset");
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R10 boundary");
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R10 boundary");
    cycle(1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, "R8 load over count");
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 8'h77, "R8 reset over load");

    cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h6C, "R3 preset");
    rst_n = 1'b0;
    #1;
    chk("R1 async zero before edge", {a_hi, a_lo}, 8'h00);
    chk("R2 sync holds before edge", {s_hi, s_lo}, 8'h6C);
    model = 8'h00;
    @(posedge clk); #1;
    chk("R2 sync zero after edge", {s_hi, s_lo}, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic r, l, p, t;
      logic [7:0] pre;
      r   = ($urandom_range(99) >= 2);
      l   = ($urandom_range(99) >= 6);
      p   = ($urandom_range(99) >= 15);
      t   = ($urandom_range(99) >= 10);
      pre = 8'($urandom);
      cycle(r, l, p, t, pre, tag_of(r, l, p, t));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule